// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits next to a processor's load/store unit and rules on conditional stores. A load-linked request from a hardware thread opens a reservation for that thread. The reservation covers the 16-byte granule that holds the physical address. A later store-conditional from the same thread is allowed to reach memory only while that reservation is still open and covers the granule being written. Each thread keeps its own reservation, chosen by the thread ID that comes with the request.

A conditional store to an uncacheable address does not go through the check. It always goes out to memory, and its result code tells the core to leave its result register unchanged. Failed conditional stores that follow one another are counted so that livelock can be diagnosed. The block gives a one-cycle warning pulse at every tenth failure in a row, and it sets a sticky error flag once 5000 failures in a row have built up.

The block takes at most one request per clock. Each response is registered and appears exactly one cycle after its request.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked request (req_is_sc=0) stores the address of the request's thread with bits [3:0] cleared and sets that thread's reservation flag. Its response has rsp_forward=1, rsp_code=0 and rsp_cause=0.
- R2: Each thread has its own reservation. A request touches only the reservation of the thread given in req_tid.
- R3: A cacheable store-conditional passes when its thread's flag is set and req_addr with bits [3:0] cleared equals the stored address. A pass gives rsp_forward=1 and rsp_code=1, and it clears the flag.
- R4: A cacheable store-conditional that does not pass gives rsp_forward=0 and rsp_code=0, and it clears the thread's flag.
- R5: rsp_cause is 1 when the flag was clear and 2 when the flag was set but the granule differs. A clear flag wins over a mismatch. rsp_cause is 0 for every other response.
- R6: An uncacheable store-conditional gives rsp_forward=1, rsp_code=2 and rsp_cause=0. It changes neither the reservation nor the failure count.
- R7: fail_count goes up by one on each failed store-conditional and returns to 0 on each passing one.
- R8: fail_warn pulses for one cycle, together with the response, whenever a failure brings fail_count to a nonzero multiple of 10.
- R9: When fail_count reaches 5000, livelock_err is set. It then stays set until reset, and fail_count stays at 5000 through further failures.
- R10: After a synchronous reset, every reservation flag is clear, fail_count is 0, livelock_err is 0 and rsp_valid is 0.
- R11: The response appears one cycle after req_valid, with rsp_valid=1. A cycle with no request gives rsp_valid=0 and rsp_forward=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_sc | input | 1 | 1 for store-conditional, 0 for load-linked |
| req_tid | input | TID_W (2) | Hardware thread of the request |
| req_addr | input | ADDR_W (32) | Physical byte address |
| req_uncached | input | 1 | Address is uncacheable (used by store-conditional only) |
| rsp_valid | output | 1 | Response present |
| rsp_forward | output | 1 | The access may go to memory |
| rsp_code | output | 2 | 0 fail, 1 pass, 2 uncacheable bypass |
| rsp_cause | output | 2 | 0 none, 1 flag clear, 2 granule mismatch |
| fail_count | output | CNT_W (13) | Failed store-conditionals in a row |
| fail_warn | output | 1 | Pulse when a failure brings the count to a multiple of 10 |
| livelock_err | output | 1 | Sticky flag for 5000 failures in a row |

## Verification
The situation hardest to reach from the ports is the livelock error. It needs 5000 failed conditional stores in a row, with no passing one in between, and a random mix almost never gets that far. A directed phase therefore sends a long run of conditional stores from a thread whose reservation is clear. It mixes uncacheable stores into the run to show that they leave the count alone. It checks every tenth pulse, the point where the error flag is set, and that the count saturates after it. A later pass then shows that the count clears while the flag stays set. A random phase with a fixed seed follows. It draws thread IDs and addresses from a small set of granules, so that both the granule-match case and the flag-versus-mismatch priority case come up often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    RC_FAIL   = 2'd0,
    RC_PASS   = 2'd1,
    RC_BYPASS = 2'd2
  } rcode_e;

  typedef enum logic [1:0] {
    CZ_NONE     = 2'd0,
    CZ_NOFLAG   = 2'd1,
    CZ_MISMATCH = 2'd2
  } cause_e;
endpackage

// File: rtl/llsc_resv_bank.sv
module llsc_resv_bank #(
  parameter int THREADS = 4,
  parameter int TID_W   = 2,
  parameter int TAG_W   = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ll_we,
  input  logic             clr_we,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TID_W-1:0] rd_tid,
  output logic             rd_flag,
  output logic [TAG_W-1:0] rd_tag
);
  // Granule tags: no reset, one write port, so the store maps to RAM.
  logic [TAG_W-1:0] tag_mem [THREADS];
  logic [THREADS-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (ll_we) tag_mem[wr_tid] <= wr_tag;
  end

  assign rd_tag  = tag_mem[rd_tid];
  assign rd_flag = flag_q[rd_tid];

  for (genvar t = 0; t < THREADS; t++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                  flag_q[t] <= 1'b0;
      else if (ll_we  && wr_tid == TID_W'(t))   flag_q[t] <= 1'b1;
      else if (clr_we && wr_tid == TID_W'(t))   flag_q[t] <= 1'b0;
    end

    assert_set_flag_R1: assert property (@(posedge clk) disable iff (rst)
      (ll_we && wr_tid == TID_W'(t)) |=> flag_q[t]);
    assert_other_thread_R2: assert property (@(posedge clk) disable iff (rst)
      ((ll_we || clr_we) && wr_tid != TID_W'(t)) |=> $stable(flag_q[t]));
    assert_clear_flag_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_we && !ll_we && wr_tid == TID_W'(t)) |=> !flag_q[t]);
  end
endmodule

// File: rtl/llsc_fail_counter.sv
module llsc_fail_counter #(
  parameter int CNT_W       = 13,
  parameter int WARN_EVERY  = 10,
  parameter int FATAL_COUNT = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_evt,
  input  logic             pass_evt,
  output logic [CNT_W-1:0] count,
  output logic             warn,
  output logic             fatal
);
  localparam int PH_W = (WARN_EVERY > 1) ? $clog2(WARN_EVERY) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FATAL_COUNT);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(WARN_EVERY - 1);

  logic [PH_W-1:0] phase;
  logic            can_inc;

  assign can_inc = fail_evt && (count != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      phase <= '0;
      warn  <= 1'b0;
      fatal <= 1'b0;
    end else begin
      warn <= 1'b0;
      if (pass_evt) begin
        count <= '0;
        phase <= '0;
      end else if (can_inc) begin
        count <= count + 1'b1;
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        warn  <= (phase == PH_LAST);
        if (count == CNT_MAX - 1'b1) fatal <= 1'b1;
      end
    end
  end

  assert_count_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (fail_evt && !pass_evt && count != CNT_MAX) |=> count == $past(count) + 1'b1);
  assert_count_clr_R7: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> count == '0);
  assert_warn_multiple_R8: assert property (@(posedge clk) disable iff (rst)
    warn |-> (count != '0 && (count % CNT_W'(WARN_EVERY)) == '0));
  assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);
  assert_fatal_at_max_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fatal) |-> count == CNT_MAX);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int THREADS     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_EVERY  = 10,
  parameter int FATAL_COUNT = 5000,
  localparam int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W      = $clog2(FATAL_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_uncached,
  output logic              rsp_valid,
  output logic              rsp_forward,
  output logic [1:0]        rsp_code,
  output logic [1:0]        rsp_cause,
  output logic [CNT_W-1:0]  fail_count,
  output logic              fail_warn,
  output logic              livelock_err
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [TAG_W-1:0] req_tag, rd_tag;
  logic rd_flag, ll_we, sc_cached, sc_bypass, hit, pass_evt, fail_evt;

  assign req_tag   = req_addr[ADDR_W-1:GRAN_BITS];
  assign ll_we     = req_valid && !req_is_sc;
  assign sc_cached = req_valid &&  req_is_sc && !req_uncached;
  assign sc_bypass = req_valid &&  req_is_sc &&  req_uncached;
  assign hit       = rd_flag && (rd_tag == req_tag);
  assign pass_evt  = sc_cached &&  hit;
  assign fail_evt  = sc_cached && !hit;

  llsc_resv_bank #(.THREADS(THREADS), .TID_W(TID_W), .TAG_W(TAG_W)) u_bank (
    .clk(clk), .rst(rst), .ll_we(ll_we), .clr_we(sc_cached),
    .wr_tid(req_tid), .wr_tag(req_tag), .rd_tid(req_tid),
    .rd_flag(rd_flag), .rd_tag(rd_tag)
  );

  llsc_fail_counter #(.CNT_W(CNT_W), .WARN_EVERY(WARN_EVERY),
                      .FATAL_COUNT(FATAL_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .fail_evt(fail_evt), .pass_evt(pass_evt),
    .count(fail_count), .warn(fail_warn), .fatal(livelock_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_forward <= 1'b0;
      rsp_code    <= RC_FAIL;
      rsp_cause   <= CZ_NONE;
    end else begin
      rsp_valid   <= req_valid;
      rsp_forward <= ll_we || sc_bypass || pass_evt;
      rsp_code    <= sc_bypass ? RC_BYPASS : (pass_evt ? RC_PASS : RC_FAIL);
      if (fail_evt) rsp_cause <= rd_flag ? CZ_MISMATCH : CZ_NOFLAG;
      else          rsp_cause <= CZ_NONE;
    end
  end

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    sc_bypass |=> (rsp_forward && rsp_code == RC_BYPASS && rsp_cause == CZ_NONE));
  assert_noflag_first_R5: assert property (@(posedge clk) disable iff (rst)
    (sc_cached && !rd_flag) |=> (rsp_cause == CZ_NOFLAG && !rsp_forward));
  assert_pass_R3: assert property (@(posedge clk) disable iff (rst)
    pass_evt |=> (rsp_forward && rsp_code == RC_PASS && fail_count == '0));
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_forward));
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int NT = 4;
  localparam int FATAL = 5000;

  logic clk = 1'b0, rst;
  logic req_valid, req_is_sc, req_uncached;
  logic [1:0] req_tid;
  logic [31:0] req_addr;
  logic rsp_valid, rsp_forward, fail_warn, livelock_err;
  logic [1:0] rsp_code, rsp_cause;
  logic [12:0] fail_count;

  int checks = 0, fails = 0;
  bit       mflag [NT];
  bit [31:0] mtag [NT];
  int mcnt = 0;
  bit merr = 0;

  always #2.5 clk = ~clk;

  llsc_monitor u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_sc(req_is_sc),
    .req_tid(req_tid), .req_addr(req_addr), .req_uncached(req_uncached),
    .rsp_valid(rsp_valid), .rsp_forward(rsp_forward), .rsp_code(rsp_code),
    .rsp_cause(rsp_cause), .fail_count(fail_count), .fail_warn(fail_warn),
    .livelock_err(livelock_err)
  );

  function automatic bit [31:0] granule(input bit [31:0] a);
    return a & 32'hFFFF_FFF0;
  endfunction

  task automatic check(input string tag, input bit ok, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  task automatic do_req(input bit sc, input int tid, input bit [31:0] addr, input bit unc);
    bit efwd, ewarn;
    int ecode, ecause;
    string tag;
    efwd = 0; ecode = 0; ecause = 0; ewarn = 0;
    if (!sc) begin
      tag = "R1"; efwd = 1;
      mflag[tid] = 1; mtag[tid] = granule(addr);
    end else if (unc) begin
      tag = "R6"; efwd = 1; ecode = 2;
    end else if (mflag[tid] && mtag[tid] == granule(addr)) begin
      tag = "R3"; efwd = 1; ecode = 1; mcnt = 0; mflag[tid] = 0;
    end else begin
      tag = "R4"; ecause = mflag[tid] ? 2 : 1; mflag[tid] = 0;
      if (mcnt < FATAL) begin
        mcnt++;
        ewarn = (mcnt % 10 == 0);
        if (mcnt == FATAL) merr = 1;
      end
    end
    req_valid = 1; req_is_sc = sc; req_tid = 2'(tid); req_addr = addr; req_uncached = unc;
    @(negedge clk);
    check(tag, rsp_valid && rsp_forward == efwd && rsp_code == 2'(ecode) && rsp_cause == 2'(ecause),
          $sformatf("v%0d f%0d c%0d z%0d", rsp_valid, rsp_forward, rsp_code, rsp_cause),
          $sformatf("v1 f%0d c%0d z%0d", efwd, ecode, ecause));
    check(ewarn ? "R8" : "R7", fail_count == 13'(mcnt) && fail_warn == ewarn && livelock_err == merr,
          $sformatf("cnt%0d w%0d e%0d", fail_count, fail_warn, livelock_err),
          $sformatf("cnt%0d w%0d e%0d", mcnt, ewarn, merr));
  endtask

  task automatic idle();
    req_valid = 0; req_is_sc = 0;
    @(negedge clk);
    check("R11", !rsp_valid && !rsp_forward,
          $sformatf("v%0d f%0d", rsp_valid, rsp_forward), "v0 f0");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit [31:0] pool [4];
    void'($urandom(32'd4242));
    pool[0] = 32'h1000_0040; pool[1] = 32'h1000_0050;
    pool[2] = 32'h2000_0040; pool[3] = 32'h1000_0440;
    rst = 1; req_valid = 0; req_is_sc = 0; req_tid = 0; req_addr = 0; req_uncached = 0;
    repeat (3) @(negedge clk);
    check("R10", !rsp_valid && fail_count == 0 && !livelock_err && !fail_warn,
          $sformatf("v%0d cnt%0d e%0d", rsp_valid, fail_count, livelock_err), "v0 cnt0 e0");
    rst = 0;
    idle();
    // R10: flags clear after reset -> cause 1 on every thread
    for (int t = 0; t < NT; t++) do_req(1, t, pool[0], 0);
    // R1/R3: same granule, different low bits passes
    do_req(0, 0, pool[0] | 32'h3, 0);
    do_req(1, 0, pool[0] | 32'hC, 0);
    do_req(1, 0, pool[0], 0);                 // R4: flag cleared by pass
    // R2: another thread's LL does not help thread 1
    do_req(0, 0, pool[1], 0);
    do_req(1, 1, pool[1], 0);
    do_req(1, 0, pool[1] | 32'h7, 0);
    // R5: mismatch cause, then flag-clear cause
    do_req(0, 2, pool[2], 0);
    do_req(1, 2, pool[3], 0);
    do_req(1, 2, pool[2], 0);
    // R6: uncached leaves reservation and counter untouched
    do_req(0, 3, pool[3], 0);
    do_req(1, 3, pool[0], 1);
    do_req(1, 3, pool[3], 0);
    idle();
    // R8/R9: long failure run with uncached stores mixed in
    for (int i = 0; i < FATAL + 5; i++) begin
      if (i % 777 == 5) do_req(1, 1, pool[2], 1);
      do_req(1, 1, pool[i % 4], 0);
    end
    check("R9", livelock_err && fail_count == 13'(FATAL),
          $sformatf("e%0d cnt%0d", livelock_err, fail_count), $sformatf("e1 cnt%0d", FATAL));
    do_req(0, 1, pool[1], 0);
    do_req(1, 1, pool[1], 0);                 // R7 clear, R9 flag stays
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) idle();
      else do_req(r > 4, int'($urandom % NT), pool[$urandom % 4] | ($urandom & 32'hF), r == 9);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule